// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Lines

This block gathers level-sensitive interrupt lines from peripherals and presents them to a CPU as a request wire plus a vector number. Each ordinary line sets a bit in a pending word. That word is ANDed with a mask that software writes, and the result decides the vector.

When exactly one masked source is active, the vector names that source. When several are active together, the vector is one shared code, and software reads the masked pending word to choose what to service first. The top two input lines skip the mask entirely. They drive their own status bits and a separate non-maskable interrupt output.

A small word-addressed register port lets software write the mask and read four words:
- the mask,
- the raw pending word,
- the masked pending word,
- the non-maskable status word.

A fifth, reserved word reads as zero. All state and all outputs are registered, and they settle one clock after an input change or a mask write.

Top module: `intr_vec_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after release, the mask, raw pending and non-maskable status words read zero, and `cpu_irq`, `cpu_vec` and `cpu_nmi` are all zero.
- R2: A word write (`bus_sel`=1, `bus_we`=1, `bus_addr[1:0]`=0) to byte offset 0x00 loads the mask, and reading 0x00 returns it. Writes to offsets 0x04, 0x08, 0x0C and 0x10, and misaligned writes, change no register.
- R3: Input line n (1 to 29) drives bit n-1 of the raw pending word at offset 0x04, following its level. Line 0 has no effect on any register or output. Raw pending bits 29 to 31 always read zero.
- R4: Offset 0x08 always reads the bitwise AND of the raw pending word and the mask.
- R5: When exactly one masked bit i (0 to 30) is set, `cpu_vec` is 0x31+i and `cpu_irq` is 1.
- R6: When two or more masked bits among bits 0 to 30 are set, `cpu_vec` is 0x30 and `cpu_irq` is 1.
- R7: When no masked bit is set, `cpu_vec` is 0 and `cpu_irq` is 0. `cpu_irq` is 1 exactly when `cpu_vec` is nonzero.
- R8: Lines 30 and 31 set or clear bits 30 and 31 of the non-maskable status word at offset 0x0C, following their levels. The mask does not affect them, and they do not appear in the raw pending word. `cpu_nmi` is 1 when any status bit is set.
- R9: Offset 0x10, any unmapped word offset, and any misaligned address read as zero.
- R10: The register words and all three outputs change on the first rising clock edge after an input line change or a mask write, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | Level-sensitive interrupt lines, synchronous to clk |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 5 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| cpu_irq | output | 1 | Maskable interrupt request |
| cpu_vec | output | 8 | Interrupt vector number |
| cpu_nmi | output | 1 | Non-maskable interrupt request |

## Verification
The assertions check four properties on every cycle:
- the request wire agrees with the vector being nonzero;
- more than one masked bit forces the shared code;
- a single masked bit gives a vector in the per-source range;
- a write outside the mask leaves the mask untouched and the non-maskable output tracks its status word.

Only the bench scenarios can show the exact per-source vector for each line and the shared code for every pair of lines. They also show the line-to-bit mapping, the read-back of each word, and the one-cycle latency measured against the cycle before the edge.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

   // Word index (byte offset / 4) of each register in the port map.
   typedef enum logic [2:0] {
      IVC_W_MASK   = 3'd0,
      IVC_W_RAW    = 3'd1,
      IVC_W_MASKED = 3'd2,
      IVC_W_NMI    = 3'd3,
      IVC_W_RSVD   = 3'd4
   } ivc_word_e;

endpackage

// File: rtl/ivc_sources.sv
module ivc_sources #(
   parameter int NUM_LINES = 32,
   parameter int NMI_COUNT = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lines_i,
   output logic [NUM_LINES-1:0] raw_d_o,
   output logic [NUM_LINES-1:0] raw_q_o,
   output logic [NUM_LINES-1:0] nmi_d_o,
   output logic [NUM_LINES-1:0] nmi_q_o
);

   localparam int ORD_BITS = NUM_LINES - NMI_COUNT - 1;   // lines 1..ORD_BITS
   localparam logic [NUM_LINES-1:0] RAW_KEEP =
      (NUM_LINES'(1) << ORD_BITS) - NUM_LINES'(1);
   localparam logic [NUM_LINES-1:0] NMI_KEEP =
      ~((NUM_LINES'(1) << (NUM_LINES - NMI_COUNT)) - NUM_LINES'(1));

   // Line 0 is shifted out; the top lines are masked out of the raw word.
   assign raw_d_o = (lines_i >> 1) & RAW_KEEP;
   assign nmi_d_o = lines_i & NMI_KEEP;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw_q_o <= '0;
         nmi_q_o <= '0;
      end else begin
         raw_q_o <= raw_d_o;
         nmi_q_o <= nmi_d_o;
      end
   end

endmodule

// File: rtl/ivc_regs.sv
module ivc_regs
   import ivc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] raw_q_i,
   input  logic [DATA_W-1:0] masked_q_i,
   input  logic [DATA_W-1:0] nmi_q_i,
   output logic [DATA_W-1:0] mask_d_o,
   output logic [DATA_W-1:0] mask_q_o,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word_idx;
   logic              aligned;
   logic              mask_hit;

   assign word_idx = addr_i[ADDR_W-1:2];
   assign aligned  = (addr_i[1:0] == 2'b00);
   assign mask_hit = sel_i && we_i && aligned && (word_idx == WORD_W'(IVC_W_MASK));
   assign mask_d_o = mask_hit ? wdata_i : mask_q_o;

   always_ff @(posedge clk) begin
      if (!rst_n) mask_q_o <= '0;
      else        mask_q_o <= mask_d_o;
   end

   always_comb begin
      rdata_o = '0;
      if (aligned) begin
         case (word_idx)
            WORD_W'(IVC_W_MASK):   rdata_o = mask_q_o;
            WORD_W'(IVC_W_RAW):    rdata_o = raw_q_i;
            WORD_W'(IVC_W_MASKED): rdata_o = masked_q_i;
            WORD_W'(IVC_W_NMI):    rdata_o = nmi_q_i;
            default:               rdata_o = '0;
         endcase
      end
   end

   // R2: only an aligned write to the mask word may change the mask
   assert_ro_words_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && we_i && (!aligned || word_idx != WORD_W'(IVC_W_MASK)))
         |=> $stable(mask_q_o));

endmodule

// File: rtl/ivc_vec_enc.sv
module ivc_vec_enc #(
   parameter int                SCAN_W   = 31,
   parameter int                VEC_W    = 8,
   parameter logic [VEC_W-1:0]  VEC_BASE = 8'h30
) (
   input  logic [SCAN_W-1:0] scan_i,
   output logic [VEC_W-1:0]  vec_o
);

   localparam int IDX_W = (SCAN_W > 1) ? $clog2(SCAN_W) : 1;

   logic [IDX_W-1:0] low_idx;
   logic             any_set;
   logic             many_set;

   // Lowest set bit, plus a flag for a second set bit above it.
   always_comb begin
      low_idx  = '0;
      any_set  = 1'b0;
      many_set = 1'b0;
      for (int b = 0; b < SCAN_W; b++) begin
         if (scan_i[b]) begin
            if (any_set) many_set = 1'b1;
            else         low_idx  = IDX_W'(b);
            any_set = 1'b1;
         end
      end
   end

   always_comb begin
      if (!any_set)     vec_o = '0;
      else if (many_set) vec_o = VEC_BASE;
      else               vec_o = VEC_BASE + VEC_W'(1) + VEC_W'(low_idx);
   end

endmodule

// File: rtl/intr_vec_ctrl.sv
module intr_vec_ctrl #(
   parameter int               NUM_LINES = 32,
   parameter int               NMI_COUNT = 2,
   parameter int               ADDR_W    = 5,
   parameter int               VEC_W     = 8,
   parameter logic [VEC_W-1:0] VEC_BASE  = 8'h30
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [NUM_LINES-1:0] bus_wdata,
   output logic [NUM_LINES-1:0] bus_rdata,
   output logic                 cpu_irq,
   output logic [VEC_W-1:0]     cpu_vec,
   output logic                 cpu_nmi
);

   localparam int SCAN_W = NUM_LINES - 1;

   // Elaboration-time parameter checks.
   generate
      if (NUM_LINES < 4 || NUM_LINES > 32) begin : g_bad_lines
         $error("intr_vec_ctrl: NUM_LINES must be 4..32");
      end
      if (NMI_COUNT < 1 || NMI_COUNT >= NUM_LINES - 1) begin : g_bad_nmi
         $error("intr_vec_ctrl: NMI_COUNT out of range");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("intr_vec_ctrl: ADDR_W must hold five words");
      end
      if (int'(VEC_BASE) + NUM_LINES >= (1 << VEC_W)) begin : g_bad_vec
         $error("intr_vec_ctrl: vector range overflows VEC_W");
      end
   endgenerate

   logic [NUM_LINES-1:0] raw_d, raw_q, nmi_d, nmi_q;
   logic [NUM_LINES-1:0] mask_d, mask_q, masked_q;
   logic [SCAN_W-1:0]    scan_d;
   logic [VEC_W-1:0]     vec_d;

   ivc_sources #(.NUM_LINES(NUM_LINES), .NMI_COUNT(NMI_COUNT)) i_sources (
      .clk(clk), .rst_n(rst_n), .lines_i(irq_lines),
      .raw_d_o(raw_d), .raw_q_o(raw_q), .nmi_d_o(nmi_d), .nmi_q_o(nmi_q)
   );

   assign masked_q = raw_q & mask_q;

   ivc_regs #(.DATA_W(NUM_LINES), .ADDR_W(ADDR_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .sel_i(bus_sel), .we_i(bus_we),
      .addr_i(bus_addr), .wdata_i(bus_wdata),
      .raw_q_i(raw_q), .masked_q_i(masked_q), .nmi_q_i(nmi_q),
      .mask_d_o(mask_d), .mask_q_o(mask_q), .rdata_o(bus_rdata)
   );

   // Next-state masked word so outputs land on the same edge as the registers.
   assign scan_d = raw_d[SCAN_W-1:0] & mask_d[SCAN_W-1:0];

   ivc_vec_enc #(.SCAN_W(SCAN_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) i_enc (
      .scan_i(scan_d), .vec_o(vec_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_vec <= '0;
         cpu_irq <= 1'b0;
         cpu_nmi <= 1'b0;
      end else begin
         cpu_vec <= vec_d;
         cpu_irq <= (vec_d != '0);
         cpu_nmi <= (nmi_d != '0);
      end
   end

   // R7: request wire high exactly when a vector is presented
   assert_irq_matches_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq == (cpu_vec != '0));

   // R7: nothing masked means no vector
   assert_idle_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (masked_q[SCAN_W-1:0] == '0) |-> (cpu_vec == '0));

   // R6: several masked sources give the shared code
   assert_shared_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(masked_q[SCAN_W-1:0]) > 1) |-> (cpu_vec == VEC_BASE));

   // R5: a lone masked source gives a per-source vector
   assert_single_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(masked_q[SCAN_W-1:0]) == 1) |->
         (cpu_vec > VEC_BASE && cpu_vec <= VEC_BASE + VEC_W'(SCAN_W)));

   // R8: non-maskable output follows its status word
   assert_nmi_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_nmi == (nmi_q != '0));

endmodule

// File: tb/test_intr_vec_ctrl.sv
`timescale 1ns/100ps
module test_intr_vec_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_lines = '0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cpu_irq;
   logic [7:0]  cpu_vec;
   logic        cpu_nmi;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   intr_vec_ctrl i_intr_vec_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cpu_irq(cpu_irq), .cpu_vec(cpu_vec), .cpu_nmi(cpu_nmi)
   );

   function automatic logic [31:0] exp_raw(input logic [31:0] l);
      return (l >> 1) & 32'h1FFF_FFFF;
   endfunction

   function automatic logic [7:0] exp_vec(input logic [31:0] m);
      int n = 0;
      int first = 0;
      for (int b = 30; b >= 0; b--) if (m[b]) begin n++; first = b; end
      if (n == 0) return 8'h00;
      if (n > 1)  return 8'h30;
      return 8'(8'h31 + first);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic drive(input logic [31:0] l);
      irq_lines = l; step();
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      step();
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a; #0.5; d = bus_rdata;
   endtask

   task automatic outputs(input string req, input logic [31:0] m);
      logic [7:0] ev;
      ev = exp_vec(m);
      check(req, {24'd0, cpu_vec}, {24'd0, ev});
      check(req, {31'd0, cpu_irq}, {31'd0, ev != 0});
   endtask

   initial begin
      #(4 * 150000);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v, lfsr, m;
      irq_lines = 32'hFFFF_FFFF;     // held during reset, must not leak
      repeat (3) @(negedge clk);
      // R1: reset state
      rd(5'h00, v); check("R1 mask", v, 0);
      rd(5'h04, v); check("R1 raw", v, 0);
      rd(5'h0C, v); check("R1 nmi", v, 0);
      check("R1 outs", {cpu_nmi, cpu_irq, cpu_vec}, 0);
      irq_lines = '0;
      rst_n = 1'b1;
      #0.5; check("R1 after release", {cpu_nmi, cpu_irq, cpu_vec}, 0);
      step();

      // R2: mask write and readback
      wr(5'h00, 32'hFFFF_FFFF);
      rd(5'h00, v); check("R2 mask readback", v, 32'hFFFF_FFFF);
      wr(5'h00, 32'hA5C3_0F96);
      rd(5'h00, v); check("R2 mask readback2", v, 32'hA5C3_0F96);
      // R2: other offsets and misaligned writes ignored
      for (int k = 1; k <= 4; k++) begin
         wr(5'(k * 4), 32'h0000_0000);
         rd(5'h00, v); check("R2 ro offset", v, 32'hA5C3_0F96);
      end
      wr(5'h01, 32'h0);
      rd(5'h00, v); check("R2 misaligned", v, 32'hA5C3_0F96);
      rd(5'h04, v); check("R2 raw untouched", v, 0);

      // R10: latency of a line change
      wr(5'h00, 32'hFFFF_FFFF);
      irq_lines = 32'h0000_0020;
      #0.5; check("R10 before edge vec", {24'd0, cpu_vec}, 0);
      rd(5'h04, v); check("R10 before edge raw", v, 0);
      step();
      check("R10 after edge vec", {24'd0, cpu_vec}, 32'h35);
      // R10: latency of a mask write
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'h00; bus_wdata = 32'h0;
      #0.5; check("R10 before mask edge irq", {31'd0, cpu_irq}, 1);
      step(); bus_sel = 1'b0; bus_we = 1'b0;
      check("R10 after mask edge irq", {31'd0, cpu_irq}, 0);

      // R3/R5: every ordinary line alone, full mask
      wr(5'h00, 32'hFFFF_FFFF);
      for (int n = 1; n <= 29; n++) begin
         drive(32'(1) << n);
         rd(5'h04, v); check("R3 line to raw bit", v, exp_raw(32'(1) << n));
         check("R5 single vector", {24'd0, cpu_vec}, 32'(8'h31 + n - 1));
         check("R5 single irq", {31'd0, cpu_irq}, 1);
      end
      // R3: line 0 no effect
      drive(32'h0000_0001);
      rd(5'h04, v); check("R3 line0 raw", v, 0);
      outputs("R3 line0 outputs", 0);
      rd(5'h0C, v); check("R3 line0 nmi", v, 0);

      // R7: source active but masked off
      for (int n = 1; n <= 29; n++) begin
         wr(5'h00, ~(32'(1) << (n - 1)));
         drive(32'(1) << n);
         check("R7 masked off vec", {24'd0, cpu_vec}, 0);
         check("R7 masked off irq", {31'd0, cpu_irq}, 0);
      end

      // R6: every pair of ordinary lines
      wr(5'h00, 32'hFFFF_FFFF);
      for (int i = 1; i <= 29; i++) begin
         for (int j = i + 1; j <= 29; j++) begin
            drive((32'(1) << i) | (32'(1) << j));
            check("R6 pair vec", {24'd0, cpu_vec}, 32'h30);
         end
      end
      // R6: all ordinary lines
      drive(32'h3FFF_FFFE);
      outputs("R6 all lines", 32'h1FFF_FFFF);

      // R4: pseudo-random patterns against masked word and vector
      lfsr = 32'h1234_5679;
      for (int k = 0; k < 60; k++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         m = lfsr;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         if (k % 3 == 0) m = m & (m - 1) & ((m & (m - 1)) - 1);
         wr(5'h00, m);
         drive(lfsr & 32'h3FFF_FFFF);
         rd(5'h08, v); check("R4 masked word", v, exp_raw(lfsr & 32'h3FFF_FFFF) & m);
         outputs("R4 pattern outputs", exp_raw(lfsr & 32'h3FFF_FFFF) & m);
      end

      // R8: non-maskable lines
      wr(5'h00, 32'h0);
      drive(32'h4000_0000);
      rd(5'h0C, v); check("R8 nmi bit30", v, 32'h4000_0000);
      rd(5'h04, v); check("R8 not in raw", v, 0);
      check("R8 nmi out", {31'd0, cpu_nmi}, 1);
      check("R8 no irq", {31'd0, cpu_irq}, 0);
      drive(32'h8000_0000);
      rd(5'h0C, v); check("R8 nmi bit31", v, 32'h8000_0000);
      drive(32'hC000_0000);
      rd(5'h0C, v); check("R8 nmi both", v, 32'hC000_0000);
      drive(32'h0);
      rd(5'h0C, v); check("R8 nmi clear", v, 0);
      check("R8 nmi out low", {31'd0, cpu_nmi}, 0);

      // R9: reserved, unmapped, misaligned reads
      wr(5'h00, 32'hFFFF_FFFF);
      drive(32'hFFFF_FFFF);
      rd(5'h10, v); check("R9 reserved", v, 0);
      rd(5'h14, v); check("R9 unmapped", v, 0);
      rd(5'h1C, v); check("R9 unmapped top", v, 0);
      rd(5'h06, v); check("R9 misaligned", v, 0);
      rd(5'h04, v); check("R3 raw high bits zero", v, 32'h1FFF_FFFF);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule